// File: doc/BRIEF.md
# Three-Tier Debug Signal Observation Selector

This block brings one chosen byte of internal state out to a single debug observation bus. The observable signals are grouped into 8-bit lanes that sit in units, and units sit in partitions. Each unit has a selector that picks one of its lanes. Each partition has a selector that picks one of its unit results. One central selector picks one partition result and drives the observation bus. Each tier registers its result, so the path from a source lane to the bus is a short pipeline.

Every selector is a small register in one bank, and a single-cycle write port programs the bank. Debug software programs the selectors from the bus endpoint backwards. After that, the observation bus follows the chosen lane continuously, with a fixed delay. With the default parameters the block has 4 partitions of 4 units, and each unit has 8 lanes of 8 bits.

Top module: `dbg_obs_mux`

## Requirements
- R1: A rising edge with `rst_n` low clears the observation bus to zero and sets every selector to zero on that edge. After release, with no writes, the bus shows lane 0 of unit 0 of partition 0.
- R2: The selector of unit u in partition p is at address p*4+u. Its value g (3 bits) picks lane g. Lane g of that unit is `sig_in[8*((p*4+u)*8+g) +: 8]`.
- R3: The selector of partition p is at address 16+p. Its value (2 bits) picks which of that partition's four unit results goes forward.
- R4: The central selector is at address 20. Its value (2 bits) picks which partition result drives `obs_out`.
- R5: A change on a selected lane appears on `obs_out` after exactly three rising edges. Changes on consecutive cycles come out on consecutive cycles.
- R6: A write takes effect on the edge that samples it. `obs_out` shows the new routing one edge later for the central selector, two edges later for a partition selector and three edges later for a unit selector.
- R7: A write to an address from 21 to 31 changes no selector.
- R8: With `cfg_we` low, `cfg_addr` and `cfg_wdata` have no effect.
- R9: A write stores only the low bits of `cfg_wdata`: 3 bits for a unit selector and 2 bits for a partition or central selector. The upper bits are ignored.
- R10: A write changes only the selector at its own address. Every other unit, partition and central selector keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sig_in | input | 1024 | All observable lanes, packed by partition, then unit, then lane |
| cfg_we | input | 1 | Selector write strobe |
| cfg_addr | input | 5 | Selector address |
| cfg_wdata | input | 8 | Selector write value (low bits used) |
| obs_out | output | 8 | Registered observation bus |

## Verification
The bench checks the bus on the exact edges around each change.

- **Per-tier write delay:** it checks the edge before and the edge after a write reaches the bus, for each tier. A design with a missing or extra register in a tier shows the new value one edge early or one edge late.
- **Lane-change pipelining:** it changes the lanes on two back-to-back cycles. A design that drops an intermediate value fails this check.
- **Unmapped addresses:** it writes to addresses that alias the live unit address or the central address when bits are dropped. A design that decodes only part of the address corrupts the route and changes the bus.
- **Other corner cases:** it writes values with their upper bits set, leaves `cfg_we` low while the other write inputs change, and sweeps all sixteen units. These checks catch a design that truncates the write value wrongly, writes without the strobe, or lets one write spill into a neighbouring selector.

// File: rtl/dbg_obs_pkg.sv
// Package dbg_obs_pkg
// Shared helpers for the observation selector. It provides the tier
// classification that the address decoder produces, and a width helper
// that stays legal when a count is 1.
package dbg_obs_pkg;

    typedef enum logic [1:0] {
        TIER_UNIT = 2'd0,
        TIER_PART = 2'd1,
        TIER_CENT = 2'd2,
        TIER_NONE = 2'd3
    } tier_e;

    // Bits needed to select among n items (at least 1).
    function automatic int sel_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/dbg_obs_sel_stage.sv
// Module dbg_obs_sel_stage
// One registered selection tier. It picks one of N_IN lanes of width W
// with a binary selector and registers the result.
// Assumes: din packs lane i at bits [i*W +: W]. A selector value of
// N_IN or more gives zero.
module dbg_obs_sel_stage #(
    parameter int N_IN  = 8,
    parameter int W     = 8,
    parameter int SEL_W = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N_IN*W-1:0]   din,
    input  logic [SEL_W-1:0]    sel,
    output logic [W-1:0]        dout
);

    logic [W-1:0] pick;

    // Combinational lane pick driven by the selector.
    always_comb begin
        pick = '0;
        for (int i = 0; i < N_IN; i++) begin
            if (sel == SEL_W'(i)) begin
                pick = din[i*W +: W];
            end
        end
    end

    // Register the picked lane; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout <= '0;
        end else begin
            dout <= pick;
        end
    end

endmodule

// File: rtl/dbg_obs_cfg_regs.sv
// Module dbg_obs_cfg_regs
// The selector register bank.
//   - Unit selectors are at addresses 0 .. N_USEL-1.
//   - Partition selectors follow them.
//   - The central selector is at the next address.
//   - Any higher address is decoded as TIER_NONE and ignored.
// A write stores the low bits of the write data on the edge that samples
// it. Reset clears every selector.
// Assumes: DATA_W is at least the widest selector.
module dbg_obs_cfg_regs
    import dbg_obs_pkg::*;
#(
    parameter int N_PART = 4,
    parameter int N_UNIT = 4,
    parameter int USW    = 3,
    parameter int PSW    = 2,
    parameter int CSW    = 2,
    parameter int ADDR_W = 5,
    parameter int DATA_W = 8,
    localparam int N_USEL = N_PART * N_UNIT
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_we,
    input  logic [ADDR_W-1:0]      cfg_addr,
    input  logic [DATA_W-1:0]      cfg_wdata,
    output logic [N_USEL*USW-1:0]  unit_sel_flat,
    output logic [N_PART*PSW-1:0]  part_sel_flat,
    output logic [CSW-1:0]         cent_sel
);

    localparam int PART_BASE = N_USEL;
    localparam int CENT_ADDR = N_USEL + N_PART;

    tier_e             dec_tier;
    logic [ADDR_W-1:0] dec_idx;

    // Decode the address into a tier and an index within that tier.
    always_comb begin
        dec_tier = TIER_NONE;
        dec_idx  = '0;
        if (int'(cfg_addr) < PART_BASE) begin
            dec_tier = TIER_UNIT;
            dec_idx  = cfg_addr;
        end else if (int'(cfg_addr) < CENT_ADDR) begin
            dec_tier = TIER_PART;
            dec_idx  = cfg_addr - ADDR_W'(PART_BASE);
        end else if (int'(cfg_addr) == CENT_ADDR) begin
            dec_tier = TIER_CENT;
        end
    end

    for (genvar i = 0; i < N_USEL; i++) begin : g_unit_reg
        // Unit selector i: load the low bits on an addressed write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                unit_sel_flat[i*USW +: USW] <= '0;
            end else if (cfg_we && dec_tier == TIER_UNIT &&
                         dec_idx == ADDR_W'(i)) begin
                unit_sel_flat[i*USW +: USW] <= cfg_wdata[USW-1:0];
            end
        end
    end

    for (genvar p = 0; p < N_PART; p++) begin : g_part_reg
        // Partition selector p: load the low bits on an addressed write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                part_sel_flat[p*PSW +: PSW] <= '0;
            end else if (cfg_we && dec_tier == TIER_PART &&
                         dec_idx == ADDR_W'(p)) begin
                part_sel_flat[p*PSW +: PSW] <= cfg_wdata[PSW-1:0];
            end
        end
    end

    // Central selector: load the low bits on an addressed write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cent_sel <= '0;
        end else if (cfg_we && dec_tier == TIER_CENT) begin
            cent_sel <= cfg_wdata[CSW-1:0];
        end
    end

endmodule

// File: rtl/dbg_obs_partition.sv
// Module dbg_obs_partition
// One partition. It has N_UNIT registered unit tiers, each choosing a lane
// from its own N_GRP lanes, and one registered partition tier that chooses
// among the unit results.
// Assumes: din packs unit u, lane g at bits [(u*N_GRP+g)*W +: W].
module dbg_obs_partition #(
    parameter int N_UNIT = 4,
    parameter int N_GRP  = 8,
    parameter int W      = 8,
    parameter int USW    = 3,
    parameter int PSW    = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [N_UNIT*N_GRP*W-1:0] din,
    input  logic [N_UNIT*USW-1:0]     unit_sel,
    input  logic [PSW-1:0]            part_sel,
    output logic [W-1:0]              part_q
);

    logic [N_UNIT*W-1:0] unit_q;

    for (genvar u = 0; u < N_UNIT; u++) begin : g_unit
        dbg_obs_sel_stage #(
            .N_IN (N_GRP),
            .W    (W),
            .SEL_W(USW)
        ) u_unit_stage (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (din[u*N_GRP*W +: N_GRP*W]),
            .sel  (unit_sel[u*USW +: USW]),
            .dout (unit_q[u*W +: W])
        );
    end

    dbg_obs_sel_stage #(
        .N_IN (N_UNIT),
        .W    (W),
        .SEL_W(PSW)
    ) u_part_stage (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (unit_q),
        .sel  (part_sel),
        .dout (part_q)
    );

endmodule

// File: rtl/dbg_obs_mux.sv
// Module dbg_obs_mux (top)
// Three-tier observation selector: unit, then partition, then central.
// Each tier is registered, so a lane reaches obs_out three edges after it
// is sampled. The register bank drives all selectors.
// Assumes: sig_in packs partition p, unit u, lane g at bits
// [((p*N_UNIT+u)*N_GRP+g)*LANE_W +: LANE_W].
module dbg_obs_mux
    import dbg_obs_pkg::*;
#(
    parameter int N_PART = 4,
    parameter int N_UNIT = 4,
    parameter int N_GRP  = 8,
    parameter int LANE_W = 8,
    parameter int CFG_DW = 8,
    localparam int USW    = sel_width(N_GRP),
    localparam int PSW    = sel_width(N_UNIT),
    localparam int CSW    = sel_width(N_PART),
    localparam int N_USEL = N_PART * N_UNIT,
    localparam int N_REGS = N_USEL + N_PART + 1,
    localparam int ADDR_W = sel_width(N_REGS),
    localparam int PART_IN_W = N_UNIT * N_GRP * LANE_W,
    localparam int SIG_W  = N_PART * PART_IN_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [SIG_W-1:0]   sig_in,
    input  logic               cfg_we,
    input  logic [ADDR_W-1:0]  cfg_addr,
    input  logic [CFG_DW-1:0]  cfg_wdata,
    output logic [LANE_W-1:0]  obs_out
);

    logic [N_USEL*USW-1:0]    unit_sel_flat;
    logic [N_PART*PSW-1:0]    part_sel_flat;
    logic [CSW-1:0]           cent_sel;
    logic [N_PART*LANE_W-1:0] part_res;

    dbg_obs_cfg_regs #(
        .N_PART(N_PART),
        .N_UNIT(N_UNIT),
        .USW   (USW),
        .PSW   (PSW),
        .CSW   (CSW),
        .ADDR_W(ADDR_W),
        .DATA_W(CFG_DW)
    ) u_cfg (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_we       (cfg_we),
        .cfg_addr     (cfg_addr),
        .cfg_wdata    (cfg_wdata),
        .unit_sel_flat(unit_sel_flat),
        .part_sel_flat(part_sel_flat),
        .cent_sel     (cent_sel)
    );

    for (genvar p = 0; p < N_PART; p++) begin : g_part
        dbg_obs_partition #(
            .N_UNIT(N_UNIT),
            .N_GRP (N_GRP),
            .W     (LANE_W),
            .USW   (USW),
            .PSW   (PSW)
        ) u_part (
            .clk     (clk),
            .rst_n   (rst_n),
            .din     (sig_in[p*PART_IN_W +: PART_IN_W]),
            .unit_sel(unit_sel_flat[p*N_UNIT*USW +: N_UNIT*USW]),
            .part_sel(part_sel_flat[p*PSW +: PSW]),
            .part_q  (part_res[p*LANE_W +: LANE_W])
        );
    end

    dbg_obs_sel_stage #(
        .N_IN (N_PART),
        .W    (LANE_W),
        .SEL_W(CSW)
    ) u_cent_stage (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (part_res),
        .sel  (cent_sel),
        .dout (obs_out)
    );

endmodule

// File: rtl/dbg_obs_mux_chk.sv
// Module dbg_obs_mux_chk
// Property checker for dbg_obs_mux, attached by bind. It watches the ports
// and the selector registers that the bank drives.
// Assumes: the same address map and widths as the top.
module dbg_obs_mux_chk #(
    parameter int N_PART = 4,
    parameter int N_USEL = 16,
    parameter int USW    = 3,
    parameter int PSW    = 2,
    parameter int CSW    = 2,
    parameter int ADDR_W = 5,
    parameter int CFG_DW = 8,
    parameter int LANE_W = 8,
    parameter int SIG_W  = 1024
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [SIG_W-1:0]       sig_in,
    input logic                   cfg_we,
    input logic [ADDR_W-1:0]      cfg_addr,
    input logic [CFG_DW-1:0]      cfg_wdata,
    input logic [LANE_W-1:0]      obs_out,
    input logic [N_USEL*USW-1:0]  unit_sel_flat,
    input logic [N_PART*PSW-1:0]  part_sel_flat,
    input logic [CSW-1:0]         cent_sel
);

    localparam int CENT_ADDR = N_USEL + N_PART;

    logic              prev_we;
    logic [ADDR_W-1:0] prev_addr;
    logic [CFG_DW-1:0] prev_data;
    logic [SIG_W-1:0]  sig_q;
    logic [2:0]        quiet;

    // Remember the last write and count the quiet edges since any change.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_we   <= 1'b0;
            prev_addr <= '0;
            prev_data <= '0;
            sig_q     <= '0;
            quiet     <= '0;
        end else begin
            prev_we   <= cfg_we;
            prev_addr <= cfg_addr;
            prev_data <= cfg_wdata;
            sig_q     <= sig_in;
            if (cfg_we || sig_in != sig_q) begin
                quiet <= '0;
            end else if (quiet != 3'd7) begin
                quiet <= quiet + 3'd1;
            end
        end
    end

    assert_reset_clears_obs_R1: assert property (@(posedge clk)
        !rst_n |=> obs_out == '0);

    assert_reset_clears_sel_R1: assert property (@(posedge clk)
        !rst_n |=> (unit_sel_flat == '0 && part_sel_flat == '0 && cent_sel == '0));

    // R2 and R9: the stored unit value is the low bits of the written data.
    assert_unit_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (prev_we && int'(prev_addr) < N_USEL) |->
        unit_sel_flat[int'(prev_addr)*USW +: USW] == prev_data[USW-1:0]);

    assert_part_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (prev_we && int'(prev_addr) >= N_USEL && int'(prev_addr) < CENT_ADDR) |->
        part_sel_flat[(int'(prev_addr)-N_USEL)*PSW +: PSW] == prev_data[PSW-1:0]);

    assert_cent_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (prev_we && int'(prev_addr) == CENT_ADDR) |-> cent_sel == prev_data[CSW-1:0]);

    assert_steady_obs_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (quiet >= 3'd5) |-> $stable(obs_out));

    assert_unmapped_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && int'(cfg_addr) > CENT_ADDR) |=>
        ($stable(unit_sel_flat) && $stable(part_sel_flat) && $stable(cent_sel)));

    assert_idle_no_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=>
        ($stable(unit_sel_flat) && $stable(part_sel_flat) && $stable(cent_sel)));

    assert_unit_write_local_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && int'(cfg_addr) < N_USEL) |=>
        ($stable(part_sel_flat) && $stable(cent_sel)));

endmodule

bind dbg_obs_mux dbg_obs_mux_chk #(
    .N_PART(N_PART),
    .N_USEL(N_USEL),
    .USW   (USW),
    .PSW   (PSW),
    .CSW   (CSW),
    .ADDR_W(ADDR_W),
    .CFG_DW(CFG_DW),
    .LANE_W(LANE_W),
    .SIG_W (SIG_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sig_in       (sig_in),
    .cfg_we       (cfg_we),
    .cfg_addr     (cfg_addr),
    .cfg_wdata    (cfg_wdata),
    .obs_out      (obs_out),
    .unit_sel_flat(unit_sel_flat),
    .part_sel_flat(part_sel_flat),
    .cent_sel     (cent_sel)
);

// File: tb/dbg_obs_mux_bench.sv
// Scoreboard bench for dbg_obs_mux. Driver tasks queue the expected bus
// value together with the cycle in which it is due. A monitor pops and
// compares each item one time unit after the falling edge.
module dbg_obs_mux_bench;

    localparam int NLANES = 128;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [1023:0] sig_in = '0;
    logic         cfg_we = 1'b0;
    logic [4:0]   cfg_addr = '0;
    logic [7:0]   cfg_wdata = '0;
    logic [7:0]   obs_out;

    int cyc = 0;
    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    typedef struct {
        int         due;
        logic [7:0] val;
        string      tag;
    } exp_t;
    exp_t q[$];

    // Bench model of the selectors (address map from the requirements).
    int usel [16];
    int psel [4];
    int csel;
    logic [7:0] seed;

    dbg_obs_mux u_dbg_obs_mux (
        .clk      (clk),
        .rst_n    (rst_n),
        .sig_in   (sig_in),
        .cfg_we   (cfg_we),
        .cfg_addr (cfg_addr),
        .cfg_wdata(cfg_wdata),
        .obs_out  (obs_out)
    );

    always #5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: compare every item that is due in this cycle.
    always begin
        @(negedge clk);
        #1;
        while (q.size() > 0 && q[0].due <= cyc) begin
            exp_t it;
            it = q.pop_front();
            n_checks++;
            if (obs_out !== it.val) begin
                n_fail++;
                $display("FAIL %s cycle %0d: obs_out=%h expected=%h",
                         it.tag, cyc, obs_out, it.val);
            end
        end
    end

    task automatic push(input int due, input logic [7:0] v, input string tag);
        exp_t it;
        it.due = due;
        it.val = v;
        it.tag = tag;
        q.push_back(it);
    endtask

    task automatic load(input logic [7:0] s);
        seed = s;
        for (int i = 0; i < NLANES; i++) sig_in[i*8 +: 8] = 8'(i) ^ s;
    endtask

    function automatic logic [7:0] model();
        int u;
        u = csel * 4 + psel[csel];
        return 8'(u * 8 + usel[u]) ^ seed;
    endfunction

    function automatic void apply_write(input int a, input logic [7:0] d);
        if (a < 16) usel[a] = int'(d[2:0]);
        else if (a < 20) psel[a-16] = int'(d[1:0]);
        else if (a == 20) csel = int'(d[1:0]);
    endfunction

    function automatic void model_reset();
        for (int i = 0; i < 16; i++) usel[i] = 0;
        for (int i = 0; i < 4; i++) psel[i] = 0;
        csel = 0;
    endfunction

    // One write cycle, called at a falling edge.
    task automatic wr(input int a, input logic [7:0] d);
        cfg_we = 1'b1;
        cfg_addr = 5'(a);
        cfg_wdata = d;
        apply_write(a, d);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Write and check the bus one edge before and on the edge it must change.
    task automatic chk_write(input int a, input logic [7:0] d, input int lat,
                             input string tag);
        logic [7:0] old_v;
        int c;
        old_v = model();
        c = cyc;
        push(c + lat - 1, old_v, tag);
        wr(a, d);
        push(c + lat, model(), tag);
        repeat (lat) @(negedge clk);
    endtask

    task automatic settle(input string tag);
        repeat (4) @(negedge clk);
        push(cyc, model(), tag);
        @(negedge clk);
    endtask

    initial begin
        int c;
        logic [7:0] old_v;
        model_reset();
        load(8'hA5);
        repeat (3) @(negedge clk);
        push(cyc, 8'h00, "R1 in reset");
        @(negedge clk);
        // R1: release and watch the default route appear after three edges.
        c = cyc;
        rst_n = 1'b1;
        push(c + 2, 8'h00, "R1 pipe clear");
        push(c + 3, 8'hA5, "R1 default route");
        repeat (4) @(negedge clk);

        // R4 R6: central selector, one edge to the bus.
        chk_write(20, 8'h02, 2, "R4 R6 central");
        // R3 R6: partition selector, two edges.
        chk_write(18, 8'h03, 3, "R3 R6 partition");
        // R2 R6: unit selector, three edges.
        chk_write(11, 8'h05, 4, "R2 R6 unit");

        // R5: a lane change takes three edges.
        old_v = model();
        c = cyc;
        load(8'h3C);
        push(c + 2, old_v, "R5 latency");
        push(c + 3, model(), "R5 latency");
        @(negedge clk);
        // R5: back-to-back lane changes come out back to back.
        c = cyc;
        load(8'h11);
        push(c + 3, model(), "R5 pipelined first");
        @(negedge clk);
        load(8'hE7);
        push(c + 4, model(), "R5 pipelined second");
        repeat (5) @(negedge clk);

        // R7: unmapped writes that alias live addresses when decoded badly.
        wr(27, 8'h00);
        wr(21, 8'h00);
        wr(31, 8'h07);
        settle("R7 unmapped");

        // R8: the write strobe is low while the address and data change.
        cfg_addr = 5'd20;
        cfg_wdata = 8'h01;
        repeat (2) @(negedge clk);
        cfg_addr = 5'd11;
        cfg_wdata = 8'h00;
        settle("R8 no strobe");

        // R9: the upper bits of the write data are dropped.
        chk_write(20, 8'hFD, 2, "R9 central low bits");
        chk_write(4, 8'hF9, 4, "R9 unit low bits");
        chk_write(17, 8'hFE, 3, "R9 partition low bits");

        // R10: program all units, then walk each route.
        for (int i = 0; i < 16; i++) wr(i, 8'((i * 3 + 1) % 8));
        for (int p = 0; p < 4; p++) begin
            wr(20, 8'(p));
            for (int u = 0; u < 4; u++) begin
                wr(16 + p, 8'(u));
                settle("R10 sweep");
            end
        end

        // R1: reset in mid-operation clears the bus and all selectors.
        c = cyc;
        rst_n = 1'b0;
        push(c + 1, 8'h00, "R1 mid reset");
        repeat (3) @(negedge clk);
        model_reset();
        c = cyc;
        rst_n = 1'b1;
        push(c + 3, model(), "R1 selectors cleared");
        repeat (5) @(negedge clk);

        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule